// File: doc/BRIEF.md
# Lockable Configuration Row Store

This block is the configuration bit store of a programmable logic fabric, together with the controller that a host uses to fill it. The store is a set of rows. A host issues one of four commands: program, verify, lock or erase. Each command carries an operation code, a row address and a data word. The controller takes a command only while it is idle. It then stays busy for a fixed number of cycles and signals the end with a one-cycle done pulse. The full contents of the store are always presented flattened on a wide output for the logic fabric to use.

A sticky security bit guards the contents. While the bit is set, verify gives back zeros and program is refused. Both refused cases raise a one-cycle error flag and leave the rows untouched. The bit can be set by its own command, or by a program command that asks for the lock once its row is written. The only way to clear the bit is an erase, which also returns every row to the erased level at the same edge. Reset models power-up of a blank store: all rows are erased and the lock is clear.

Top module: `cfg_store_ctrl`

## Requirements
- R1: After reset, busy, done and err are low, locked is low, rd_data is zero and every bit of cfg_bits equals ERASED_LEVEL (default 1).
- R2: A command is accepted on a rising edge where cmd_valid is high and busy is low. A cmd_valid seen while busy is high has no effect on the rows, the lock or rd_data.
- R3: After an accepted command, busy is high for exactly BUSY_CYC cycles (default 4), starting in the cycle after acceptance. done is high for one cycle, in the first cycle in which busy is low again.
- R4: When unlocked, program (cmd_op 2'b00) writes cmd_data into row cmd_addr only. The new row appears on cfg_bits[cmd_addr*ROW_W +: ROW_W] in the cycle after acceptance, and all other rows keep their value.
- R5: When unlocked, verify (cmd_op 2'b01) puts row cmd_addr on rd_data in the cycle after acceptance. rd_data holds that value until the next accepted command. Every other accepted command sets rd_data to zero.
- R6: The lock command (cmd_op 2'b10) sets locked in the cycle after acceptance. A program command with cmd_lock high writes its row and also sets locked in that same cycle.
- R7: While locked, verify returns zero on rd_data, and program is refused with every row left unchanged.
- R8: err is a one-cycle pulse in the cycle after acceptance. It is raised only for a refused command, that is a program or verify issued while locked. Lock and erase never raise it.
- R9: Erase (cmd_op 2'b11) is never refused. It returns every row to ERASED_LEVEL and clears locked, both visible in the cycle after acceptance.
- R10: Once set, locked stays set through every command other than erase.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset (power-up) |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | 00 program, 01 verify, 10 lock, 11 erase |
| cmd_addr | input | ADDR_W | Row address for program and verify |
| cmd_data | input | ROW_W | Row value for program |
| cmd_lock | input | 1 | With program: set the lock after writing the row |
| busy | output | 1 | Controller is executing a command |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | One-cycle pulse for a refused command |
| locked | output | 1 | Security bit state |
| rd_data | output | ROW_W | Verify readback |
| cfg_bits | output | ROWS*ROW_W | Flattened store contents for the logic fabric, row r at bits r*ROW_W upward |

## Verification
The assertions assume that cmd_op and cmd_valid are known at every rising edge after reset, and that cmd_addr always falls inside the row range. Under these assumptions, acceptance follows exactly from cmd_valid and busy. The bench changes inputs only on falling edges and always uses addresses below the default row count. It also holds cmd_valid high through a busy window on purpose, so that the rule for ignoring commands while busy is exercised, not just assumed.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;
   typedef enum logic [1:0] {
      OP_PROG   = 2'b00,
      OP_VERIFY = 2'b01,
      OP_LOCK   = 2'b10,
      OP_ERASE  = 2'b11
   } cfg_op_e;
endpackage

// File: rtl/cfg_cmd_seq.sv
// Command acceptance and fixed-length busy window with done pulse.
module cfg_cmd_seq #(
   parameter int BUSY_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   output logic accept,
   output logic busy,
   output logic done
);
   localparam int CNT_W = $clog2(BUSY_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYC);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;

   assign busy   = (cnt_q != '0);
   assign accept = cmd_valid && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         done  <= 1'b0;
      end else begin
         done <= (cnt_q == CNT_ONE);
         if (accept)
            cnt_q <= CNT_LOAD;
         else if (busy)
            cnt_q <= cnt_q - CNT_ONE;
      end
   end
endmodule

// File: rtl/cfg_lock_bit.sv
// Sticky security bit: set by request, cleared only by erase or power-up.
module cfg_lock_bit (
   input  logic clk,
   input  logic rst_n,
   input  logic set_req,
   input  logic clr_req,
   output logic locked
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         locked <= 1'b0;
      else if (clr_req)
         locked <= 1'b0;
      else if (set_req)
         locked <= 1'b1;
   end
endmodule

// File: rtl/cfg_row_array.sv
// Row storage with single-row write, whole-array erase and flat exposure.
module cfg_row_array #(
   parameter int   ROWS         = 16,
   parameter int   ROW_W        = 32,
   parameter int   ADDR_W       = 4,
   parameter logic ERASED_LEVEL = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  wr_en,
   input  logic [ADDR_W-1:0]     wr_addr,
   input  logic [ROW_W-1:0]      wr_data,
   input  logic                  erase,
   input  logic [ADDR_W-1:0]     rd_addr,
   output logic [ROW_W-1:0]      rd_row,
   output logic [ROWS*ROW_W-1:0] all_rows
);
   localparam logic [ROW_W-1:0] ERASED_ROW = {ROW_W{ERASED_LEVEL}};

   logic [ROW_W-1:0] row_q [ROWS];

   for (genvar r = 0; r < ROWS; r++) begin : g_row
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            row_q[r] <= ERASED_ROW;
         else if (erase)
            row_q[r] <= ERASED_ROW;
         else if (wr_en && (wr_addr == ADDR_W'(r)))
            row_q[r] <= wr_data;
      end
      assign all_rows[r*ROW_W +: ROW_W] = row_q[r];
   end

   assign rd_row = row_q[rd_addr];
endmodule

// File: rtl/cfg_store_ctrl.sv
// Lockable configuration row store: top level.
module cfg_store_ctrl
   import cfg_store_pkg::*;
#(
   parameter int   ROWS         = 16,
   parameter int   ROW_W        = 32,
   parameter int   ADDR_W       = $clog2(ROWS),
   parameter int   BUSY_CYC     = 4,
   parameter logic ERASED_LEVEL = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  cmd_valid,
   input  logic [1:0]            cmd_op,
   input  logic [ADDR_W-1:0]     cmd_addr,
   input  logic [ROW_W-1:0]      cmd_data,
   input  logic                  cmd_lock,
   output logic                  busy,
   output logic                  done,
   output logic                  err,
   output logic                  locked,
   output logic [ROW_W-1:0]      rd_data,
   output logic [ROWS*ROW_W-1:0] cfg_bits
);
   if (ROWS < 2 || ROWS != (1 << ADDR_W)) begin : g_bad_rows
      $error("cfg_store_ctrl: ROWS must be a power of two matching ADDR_W");
   end
   if (ROW_W < 1) begin : g_bad_width
      $error("cfg_store_ctrl: ROW_W must be positive");
   end
   if (BUSY_CYC < 1) begin : g_bad_busy
      $error("cfg_store_ctrl: BUSY_CYC must be at least 1");
   end

   logic accept;
   logic is_prog, is_verify, is_lock, is_erase;
   logic wr_en, erase_en, lock_set;
   logic [ROW_W-1:0] rd_row;

   assign is_prog   = (cmd_op == OP_PROG);
   assign is_verify = (cmd_op == OP_VERIFY);
   assign is_lock   = (cmd_op == OP_LOCK);
   assign is_erase  = (cmd_op == OP_ERASE);

   assign wr_en    = accept && is_prog && !locked;
   assign erase_en = accept && is_erase;
   assign lock_set = accept && (is_lock || (is_prog && cmd_lock));

   cfg_cmd_seq #(.BUSY_CYC(BUSY_CYC)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .accept    (accept),
      .busy      (busy),
      .done      (done)
   );

   cfg_lock_bit u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_req (lock_set),
      .clr_req (erase_en),
      .locked  (locked)
   );

   cfg_row_array #(
      .ROWS         (ROWS),
      .ROW_W        (ROW_W),
      .ADDR_W       (ADDR_W),
      .ERASED_LEVEL (ERASED_LEVEL)
   ) u_rows (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (cmd_addr),
      .wr_data  (cmd_data),
      .erase    (erase_en),
      .rd_addr  (cmd_addr),
      .rd_row   (rd_row),
      .all_rows (cfg_bits)
   );

   // Readback and refusal flag, both registered at the acceptance edge.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         err     <= 1'b0;
         rd_data <= '0;
      end else begin
         err <= accept && locked && (is_prog || is_verify);
         if (accept)
            rd_data <= (is_verify && !locked) ? rd_row : '0;
      end
   end
endmodule

// File: rtl/cfg_store_ctrl_chk.sv
module cfg_store_ctrl_chk
   import cfg_store_pkg::*;
#(
   parameter int   ROWS         = 16,
   parameter int   ROW_W        = 32,
   parameter logic ERASED_LEVEL = 1'b1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic                  cmd_valid,
   input logic [1:0]            cmd_op,
   input logic                  cmd_lock,
   input logic                  busy,
   input logic                  done,
   input logic                  err,
   input logic                  locked,
   input logic [ROW_W-1:0]      rd_data,
   input logic [ROWS*ROW_W-1:0] cfg_bits
);
   localparam logic [ROWS*ROW_W-1:0] ALL_ERASED = {ROWS*ROW_W{ERASED_LEVEL}};

   logic acc;
   assign acc = cmd_valid && !busy;

   assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> busy);
   assert_busy_ignore_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(cfg_bits));
   assert_done_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);
   assert_lock_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == OP_LOCK) |=> locked);
   assert_prog_lock_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == OP_PROG && cmd_lock) |=> locked);
   assert_locked_verify_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == OP_VERIFY && locked) |=> (rd_data == '0 && err));
   assert_locked_prog_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == OP_PROG && locked) |=> ($stable(cfg_bits) && err));
   assert_err_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err |=> !err);
   assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (cmd_op == OP_LOCK || cmd_op == OP_ERASE)) |=> !err);
   assert_erase_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && cmd_op == OP_ERASE) |=> (!locked && cfg_bits == ALL_ERASED));
   assert_lock_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (locked && !(acc && cmd_op == OP_ERASE)) |=> locked);
endmodule

bind cfg_store_ctrl cfg_store_ctrl_chk #(
   .ROWS         (ROWS),
   .ROW_W        (ROW_W),
   .ERASED_LEVEL (ERASED_LEVEL)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_valid (cmd_valid),
   .cmd_op    (cmd_op),
   .cmd_lock  (cmd_lock),
   .busy      (busy),
   .done      (done),
   .err       (err),
   .locked    (locked),
   .rd_data   (rd_data),
   .cfg_bits  (cfg_bits)
);

// File: tb/cfg_store_ctrl_tb.sv
module cfg_store_ctrl_tb;
   localparam int ROWS = 16;
   localparam int ROW_W = 32;
   localparam int ADDR_W = 4;
   localparam int BUSY_CYC = 4;
   localparam int NVEC = 15;
   // entry: op(2) addr(4) data(32) lock(1) exp_err(1) exp_rd(32) exp_locked(1)
   localparam int VW = 73;
   localparam logic [1:0] P = 2'b00, V = 2'b01, L = 2'b10, E = 2'b11;
   localparam logic [31:0] ER = 32'hFFFF_FFFF;

   localparam logic [VW-1:0] VEC [NVEC] = '{
      {V, 4'd3, 32'h0,         1'b0, 1'b0, ER,            1'b0},
      {P, 4'd3, 32'hA5A5_0F0F, 1'b0, 1'b0, 32'h0,         1'b0},
      {V, 4'd3, 32'h0,         1'b0, 1'b0, 32'hA5A5_0F0F, 1'b0},
      {P, 4'd0, 32'h1234_5678, 1'b0, 1'b0, 32'h0,         1'b0},
      {V, 4'd0, 32'h0,         1'b0, 1'b0, 32'h1234_5678, 1'b0},
      {V, 4'd5, 32'h0,         1'b0, 1'b0, ER,            1'b0},
      {L, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         1'b1},
      {V, 4'd3, 32'h0,         1'b0, 1'b1, 32'h0,         1'b1},
      {P, 4'd3, 32'h0,         1'b0, 1'b1, 32'h0,         1'b1},
      {E, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         1'b0},
      {V, 4'd3, 32'h0,         1'b0, 1'b0, ER,            1'b0},
      {P, 4'd7, 32'hCAFE_F00D, 1'b1, 1'b0, 32'h0,         1'b1},
      {V, 4'd7, 32'h0,         1'b0, 1'b1, 32'h0,         1'b1},
      {E, 4'd0, 32'h0,         1'b0, 1'b0, 32'h0,         1'b0},
      {V, 4'd7, 32'h0,         1'b0, 1'b0, ER,            1'b0}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic [1:0] cmd_op = 2'b00;
   logic [ADDR_W-1:0] cmd_addr = '0;
   logic [ROW_W-1:0] cmd_data = '0;
   logic cmd_lock = 1'b0;
   logic busy, done, err, locked;
   logic [ROW_W-1:0] rd_data;
   logic [ROWS*ROW_W-1:0] cfg_bits;

   int n_chk = 0;
   int n_err = 0;
   logic s_err, s_lk, s_busy;
   logic [31:0] s_rd;
   int lat;

   always #2 clk = ~clk;

   cfg_store_ctrl #(.ROWS(ROWS), .ROW_W(ROW_W), .ADDR_W(ADDR_W), .BUSY_CYC(BUSY_CYC)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_lock(cmd_lock),
      .busy(busy), .done(done), .err(err), .locked(locked),
      .rd_data(rd_data), .cfg_bits(cfg_bits)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] row(input int r);
      return cfg_bits[r*ROW_W +: ROW_W];
   endfunction

   // Drive one command, sample outputs in the cycle after acceptance,
   // then count cycles until done.
   task automatic issue(input logic [1:0] op, input logic [3:0] a,
                        input logic [31:0] d, input logic lk);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_data = d; cmd_lock = lk;
      @(negedge clk);
      cmd_valid = 1'b0; cmd_lock = 1'b0;
      s_err = err; s_rd = rd_data; s_lk = locked; s_busy = busy;
      lat = 0;
      while (!done && lat < 50) begin
         @(negedge clk);
         lat++;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 busy", {31'b0, busy}, 32'd0);
      chk("R1 done", {31'b0, done}, 32'd0);
      chk("R1 err", {31'b0, err}, 32'd0);
      chk("R1 locked", {31'b0, locked}, 32'd0);
      chk("R1 rd_data", rd_data, 32'd0);
      chk("R1 cfg_bits erased", {31'b0, (cfg_bits === '1)}, 32'd1);

      // Vector table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [VW-1:0] v;
         v = VEC[i];
         issue(v[72:71], v[70:67], v[66:35], v[34]);
         chk($sformatf("R8 err vec %0d", i), {31'b0, s_err}, {31'b0, v[33]});
         chk($sformatf("R5 R7 rd_data vec %0d", i), s_rd, v[32:1]);
         chk($sformatf("R6 R10 locked vec %0d", i), {31'b0, s_lk}, {31'b0, v[0]});
         if (i == 1) begin
            chk("R4 row3 written", row(3), 32'hA5A5_0F0F);
            chk("R4 row2 untouched", row(2), ER);
         end
         if (i == 8) chk("R7 row3 unchanged on refused program", row(3), 32'hA5A5_0F0F);
         if (i == 9) chk("R9 all rows erased", {31'b0, (cfg_bits === '1)}, 32'd1);
         if (i == 11) chk("R6 row7 written before lock", row(7), 32'hCAFE_F00D);
      end

      // R3 busy window length and done pulse
      issue(L, 4'd0, 32'h0, 1'b0);
      chk("R3 busy after accept", {31'b0, s_busy}, 32'd1);
      chk("R3 busy cycles", lat, BUSY_CYC);
      chk("R3 done while idle", {31'b0, busy}, 32'd0);
      @(negedge clk);
      chk("R3 done single cycle", {31'b0, done}, 32'd0);
      // R10 lock survives lock again, erase clears it
      chk("R10 still locked", {31'b0, locked}, 32'd1);
      issue(E, 4'd0, 32'h0, 1'b0);
      chk("R9 erase clears lock", {31'b0, s_lk}, 32'd0);

      // R2 command held during busy is ignored
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = P; cmd_addr = 4'd1; cmd_data = 32'h0BAD_CAFE;
      @(negedge clk);
      cmd_addr = 4'd2; cmd_data = 32'hDEAD_BEEF;
      chk("R2 busy after accept", {31'b0, busy}, 32'd1);
      repeat (2) @(negedge clk);
      cmd_valid = 1'b0;
      while (!done) @(negedge clk);
      chk("R2 row1 written", row(1), 32'h0BAD_CAFE);
      chk("R2 row2 ignored while busy", row(2), ER);
      issue(V, 4'd2, 32'h0, 1'b0);
      chk("R5 verify row2 erased", s_rd, ER);
      issue(P, 4'd4, 32'h5555_AAAA, 1'b0);
      chk("R5 rd_data zero after program", s_rd, 32'h0);
      chk("R5 rd_data held", rd_data, 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end
endmodule